// File: doc/BRIEF.md
# Gated-Oscillator PWM Switch Controller

This block is the digital timing core of a multi-channel switching-regulator controller. A counter stands in for the timing capacitor of an analog oscillator. It climbs slowly from a lower threshold to an upper threshold, then drops six times faster back to the lower threshold, and repeats. With the default step sizes and a 125 MHz clock, one ramp cycle lasts 245 clocks, which is about 510 kHz.

Every output channel has its own set-only latch that drives its power switch. The latch can turn on only while the ramp is climbing, and only if that channel's feedback says the output is below target. It turns off when the ramp starts to drop, and nothing else turns it off. So the feedback can start a conduction pulse but can never end one.

The block has one overcurrent input. While it is high, the rising ramp takes a larger step, so the climb ends sooner and the on-time is shorter. The drive is never cut directly.

All feedback and overcurrent inputs are asynchronous. Each one passes through a two-flop synchronizer before it is used.

Top module: `gated_pwm_ctrl`

## Requirements
- R1: After a synchronous reset, `ramp_rising` is 1 and every bit of `drive_en` is 0.
- R2: With `over_cur` low, the rising phase lasts ceil((HI_TH-LO_TH)/UP_STEP) clocks. That is 210 clocks with the defaults, and during it `ramp_rising` is 1.
- R3: The falling phase lasts ceil((HI_TH-LO_TH)/DN_STEP) clocks. That is 35 clocks with the defaults, and during it `ramp_rising` is 0. A full cycle is 245 clocks.
- R4: A channel's `drive_en` bit goes to 1 only if two things hold at the same clock edge: the ramp stays in or enters the rising phase, and that channel's synchronized `below_tgt` bit is 1. If `below_tgt` is already high when the falling phase ends, the drive turns on in the first rising cycle.
- R5: Once a `drive_en` bit is 1, it stays 1 for the rest of that rising phase, even if `below_tgt` returns to 0.
- R6: Every `drive_en` bit becomes 0 in the first falling-phase cycle and stays 0 for the whole falling phase, whatever `below_tgt` does.
- R7: Suppose a `below_tgt` bit rises, in the input's own clock domain, at rising-phase cycle D. Then the drive turns on at cycle D+3 and stays on until the phase ends. The pulse lasts (rise length - D - 3) clocks.
- R8: While `over_cur` is high, each rising step adds OC_STEP more. With the defaults the rising phase lasts ceil(210/3) = 70 clocks. The falling phase is not affected.
- R9: Under sustained overcurrent, a channel whose `below_tgt` is held high still conducts for the whole shortened rising phase. Any latch that gets set gives a pulse of at least one clock.
- R10: The channels are independent. One channel's `below_tgt` never changes another channel's `drive_en`.
- R11: `below_tgt` and `over_cur` act with a two-clock synchronizer delay. Their effect on the outputs follows a cycle-exact model that includes that delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| below_tgt | input | NCH | Per-channel flag, asynchronous: output below target |
| over_cur | input | 1 | Peak-current-sense flag, asynchronous |
| drive_en | output | NCH | Per-channel power switch drive enable |
| ramp_rising | output | 1 | 1 in the rising ramp phase, 0 in the falling phase |

## Verification
The bench runs a behavioural model of the ramp and the latches and compares it against the outputs on every clock. Any error in the ramp count or its direction shows up on `ramp_rising` within one phase. A latch that sets or clears wrongly is wrong on `drive_en` in the very cycle it happens. A wrong synchronizer depth shifts every drive edge by one clock, and the partial-pulse length checks catch that.

// File: rtl/gated_pwm_ctrl.sv
module gated_pwm_ctrl #(
  parameter int NCH     = 3,
  parameter int RAMP_W  = 10,
  parameter int LO_TH   = 168,
  parameter int HI_TH   = 378,
  parameter int UP_STEP = 1,
  parameter int DN_STEP = 6,
  parameter int OC_STEP = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] below_tgt,
  input  logic           over_cur,
  output logic [NCH-1:0] drive_en,
  output logic           ramp_rising
);
  localparam int SUM_W = RAMP_W + 1;

  logic [NCH-1:0] fb_m, fb_s;
  logic           oc_m, oc_s;
  logic [RAMP_W-1:0] cnt, cnt_nx;
  logic           rising_nx;
  logic [SUM_W-1:0] up_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_m <= '0; fb_s <= '0; oc_m <= 1'b0; oc_s <= 1'b0;
    end else begin
      fb_m <= below_tgt; fb_s <= fb_m;
      oc_m <= over_cur;  oc_s <= oc_m;
    end
  end

  assign up_sum = {1'b0, cnt} + SUM_W'(UP_STEP) + (oc_s ? SUM_W'(OC_STEP) : '0);

  always_comb begin
    cnt_nx    = cnt;
    rising_nx = ramp_rising;
    if (ramp_rising) begin
      if (up_sum >= SUM_W'(HI_TH)) begin
        cnt_nx    = RAMP_W'(HI_TH);
        rising_nx = 1'b0;
      end else begin
        cnt_nx = up_sum[RAMP_W-1:0];
      end
    end else begin
      if ({1'b0, cnt} <= SUM_W'(LO_TH + DN_STEP)) begin
        cnt_nx    = RAMP_W'(LO_TH);
        rising_nx = 1'b1;
      end else begin
        cnt_nx = cnt - RAMP_W'(DN_STEP);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= RAMP_W'(LO_TH);
      ramp_rising <= 1'b1;
      drive_en    <= '0;
    end else begin
      cnt         <= cnt_nx;
      ramp_rising <= rising_nx;
      drive_en    <= rising_nx ? (drive_en | fb_s) : '0;
    end
  end

  // R2
  ramp_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt >= RAMP_W'(LO_TH)) && (cnt <= RAMP_W'(HI_TH)));

  // R3
  fall_descends_chk: assert property (@(posedge clk) disable iff (rst)
    (!ramp_rising && !$past(ramp_rising)) |-> (cnt < $past(cnt)));

  // R6
  off_in_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !ramp_rising |-> (drive_en == '0));

  // R5
  hold_in_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (ramp_rising && $past(ramp_rising)) |-> ((drive_en & $past(drive_en)) == $past(drive_en)));

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      // R4
      set_needs_fb_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en[g]) |-> $past(fb_s[g]));
    end
  endgenerate
endmodule

// File: tb/gated_pwm_ctrl_test.sv
module gated_pwm_ctrl_test;
  localparam int NCH = 3, LO = 168, HI = 378, UP = 1, DN = 6, OC = 2;
  localparam int RISE    = (HI - LO + UP - 1) / UP;
  localparam int RISE_OC = (HI - LO + UP + OC - 1) / (UP + OC);
  localparam int FALL    = (HI - LO + DN - 1) / DN;

  logic clk = 0, rst = 1;
  logic [NCH-1:0] below_tgt = '0;
  logic over_cur = 0;
  logic [NCH-1:0] drive_en;
  logic ramp_rising;

  int checks = 0, errors = 0;
  string tag = "R11";
  bit done = 0;

  gated_pwm_ctrl uut (.clk(clk), .rst(rst), .below_tgt(below_tgt), .over_cur(over_cur),
                      .drive_en(drive_en), .ramp_rising(ramp_rising));

  always #4 clk = ~clk;

  int m_cnt; bit m_up; bit [NCH-1:0] m_drv, s1, s2; bit o1, o2;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = LO; m_up = 1; m_drv = '0; s1 = '0; s2 = '0; o1 = 0; o2 = 0;
    end else begin
      if (m_up) begin
        int n;
        n = m_cnt + UP + (o2 ? OC : 0);
        if (n >= HI) begin m_cnt = HI; m_up = 0; end else m_cnt = n;
      end else begin
        if (m_cnt - DN <= LO) begin m_cnt = LO; m_up = 1; end else m_cnt = m_cnt - DN;
      end
      m_drv = m_up ? (m_drv | s2) : '0;
      s2 = s1; s1 = below_tgt; o2 = o1; o1 = over_cur;
    end
  end

  task automatic chk(string t, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk({tag, " ramp_rising vs model"}, ramp_rising, m_up);
    chk({tag, " drive_en vs model"}, drive_en, m_drv);
  end

  task automatic to_rise();
    @(negedge clk);
    while (ramp_rising) @(negedge clk);
    while (!ramp_rising) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 0;
    tag = "R1";
    chk("R1 ramp_rising after reset", ramp_rising, 1);
    chk("R1 drive_en after reset", drive_en, 0);

    tag = "R2";
    @(negedge clk);
    while (ramp_rising) @(negedge clk);
    n = 0; while (!ramp_rising) begin n++; @(negedge clk); end
    chk("R3 fall length", n, FALL);
    n = 0; while (ramp_rising) begin n++; @(negedge clk); end
    chk("R2 rise length", n, RISE);

    tag = "R7";
    to_rise();
    n = 0;
    for (int k = 0; k < RISE; k++) begin
      if (k == 100) below_tgt[0] = 1;
      if (k == 120) below_tgt[0] = 0;
      if (k == 130) chk("R5 held after fb drop", drive_en[0], 1);
      if (drive_en[0]) n++;
      @(negedge clk);
    end
    chk("R7 partial pulse length", n, RISE - 100 - 3);
    chk("R6 cleared at fall start", drive_en, 0);

    tag = "R6";
    below_tgt = '1;
    n = 0;
    for (int k = 0; k < FALL; k++) begin
      if (drive_en != 0) n++;
      @(negedge clk);
    end
    chk("R6 no drive during fall", n, 0);
    chk("R4 set at first rising cycle", drive_en, 3'b111);

    tag = "R10";
    below_tgt = 3'b010;
    to_rise();
    n = 0;
    for (int k = 0; k < RISE; k++) begin
      if (drive_en == 3'b010) n++;
      @(negedge clk);
    end
    chk("R10 only channel 1 driven", n, RISE);

    tag = "R8";
    below_tgt = 3'b001; over_cur = 1;
    to_rise(); to_rise();
    n = 0; while (ramp_rising) begin n++; @(negedge clk); end
    chk("R8 rise length under overcurrent", n, RISE_OC);
    n = 0; while (!ramp_rising) begin n++; @(negedge clk); end
    chk("R8 fall length under overcurrent", n, FALL);
    n = 0; while (ramp_rising) begin if (drive_en[0]) n++; @(negedge clk); end
    chk("R9 sustained overload pulse", n, RISE_OC);

    tag = "R9";
    below_tgt = '0;
    to_rise();
    n = 0;
    for (int k = 0; k < RISE_OC; k++) begin
      if (k == RISE_OC - 4) below_tgt[2] = 1;
      if (drive_en[2]) n++;
      @(negedge clk);
    end
    below_tgt = '0;
    chk("R9 late set still conducts", n, 1);

    tag = "R11";
    for (int k = 0; k < 5000; k++) begin
      if ($urandom_range(0, 15) == 0) below_tgt = NCH'($urandom);
      if ($urandom_range(0, 31) == 0) over_cur = ~over_cur;
      @(negedge clk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule